// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Bridge

This block connects a single-cycle request interface on a synchronous clock domain to an asynchronous 16-bit static RAM. The RAM has an 18-bit word address and one active-low enable for each byte lane. A requester presents an address, a write flag, a two-bit lane mask and write data while `req_ready` is high. The bridge then runs the chip-enable, write-enable and output-enable strobes and the two lane enables for as many clock cycles as the RAM's access time requires. A read ends with a one-cycle `rsp_valid` pulse that carries the returned word.

Read latency comes from the RAM's address-to-data time and the clock period, both given as parameters. The write strobe width is a parameter of its own. Address and lane enables are set up one cycle before the write strobe falls and are held one cycle after it rises. The bridge never drives the shared data bus while the RAM could be driving it. Between accesses the RAM is deselected.

Top module: `sram_lane_bridge`

## Requirements
- R1: After reset, and with no request pending, `req_ready` is 1 and `rsp_valid` is 0. In that state `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1, and `mem_dq_oe` is 0.
- R2: A read with a non-zero mask keeps `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD_WAIT = ceil(TAA_PS/CLK_PS)+1 cycles. That is 4 cycles for 12 ns at a 4 ns clock. `rsp_valid` pulses for one cycle on the cycle that follows, RD_WAIT+1 clock edges after the accepting edge. `rsp_rdata` then holds the stored word.
- R3: Mask bit 0 selects bits 7..0 through `mem_lb_n`, and mask bit 1 selects bits 15..8 through `mem_ub_n`. A lane enable is low only during an access whose mask selects that lane. A write changes only the selected lanes. A read returns zero in each lane that is not selected.
- R4: A write with a non-zero mask runs in three parts. There is one setup cycle with `mem_ce_n` low and `mem_we_n` high. Then `mem_we_n` stays low for exactly WR_PULSE cycles. Then there is one hold cycle with `mem_ce_n` low and `mem_we_n` high. Address and lane enables do not change across the whole access. `req_ready` returns WR_PULSE+3 edges after the accepting edge.
- R5: `mem_dq_oe` is 1 only while both `mem_ce_n` and `mem_we_n` are low.
- R6: `mem_oe_n` is high whenever `mem_dq_oe` is 1. At least one cycle separates the last cycle with `mem_oe_n` low from the next cycle with `mem_dq_oe` high.
- R7: A request with a zero mask is accepted and causes no memory strobe. `req_ready` stays high. For a read of this kind, `rsp_valid` pulses on the next cycle with `rsp_rdata` equal to zero.
- R8: `req_ready` is high only in the idle state, and in that state `mem_ce_n` is high.
- R9: During an access, `mem_addr` carries the full 18-bit request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, a request is accepted |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Tri-state driver enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data bus as seen from the RAM |

## Verification
The main path is tried with full-word writes and reads, then single-lane writes over an existing word. Lane gating is told apart from whole-word behaviour when each half comes back changed or unchanged. Single-lane reads show that an unselected lane returns zero rather than stale bus data. A zero-mask write placed between a write and a read must leave the word intact and must show no strobe. A read followed directly by a write exercises bus turnaround. An address with its upper bits set shows that the whole address reaches the pins. Each access also gets its latency and its write-strobe width counted against the figures derived from the timing parameters.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } bridge_state_e;

  // cycles the read strobes stay active: access time rounded up to whole
  // clocks, plus one cycle for the data to settle at the capture flop
  function automatic int unsigned read_wait_cycles(int unsigned taa_ps,
                                                   int unsigned clk_ps);
    return (taa_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

  // bits needed by a down-counter that is loaded with (max(a,b) - 1)
  function automatic int unsigned count_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 3) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    active,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        lane_en_n,
  output logic [LANES*LANE_W-1:0] rd_merged
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en_n[g] = !(active && lane_mask[g]);
    assign rd_merged[g*LANE_W +: LANE_W] =
      lane_mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_lane_bridge.sv
module sram_lane_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 4000,
  parameter int TAA_PS   = 12000,
  parameter int WR_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int unsigned RD_WAIT = read_wait_cycles(TAA_PS, CLK_PS);
  localparam int CNT_W = count_width(RD_WAIT, WR_PULSE);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);

  bridge_state_e     state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_valid_q;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [LANES-1:0]  lane_en_n;
  logic [DATA_W-1:0] lane_rd;

  // named events, also used by the bound checker
  logic accept_w, noop_w, read_done_w, access_w;
  assign accept_w    = (state_q == ST_IDLE) && req_valid;
  assign noop_w      = accept_w && (req_mask == 2'b00);
  assign read_done_w = (state_q == ST_READ) && tmr_expired;
  assign access_w    = (state_q != ST_IDLE);

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .active    (access_w),
    .lane_mask (mask_q),
    .dq_in     (mem_dq_in),
    .lane_en_n (lane_en_n),
    .rd_merged (lane_rd)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = RD_LOAD;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_w && !noop_w) begin
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
          end
        end
      end
      ST_READ:   if (tmr_expired) state_d = ST_IDLE;
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WR_LOAD;
      end
      ST_WPULSE: if (tmr_expired) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      mask_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= read_done_w || (noop_w && !req_write);
      if (accept_w) begin
        addr_q  <= req_addr;
        mask_q  <= req_mask;
        wdata_q <= req_wdata;
      end
      if (read_done_w)              rdata_q <= lane_rd;
      else if (noop_w && !req_write) rdata_q <= '0;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !access_w;
  assign mem_oe_n   = (state_q != ST_READ);
  assign mem_we_n   = (state_q != ST_WPULSE);
  assign mem_dq_oe  = (state_q == ST_WPULSE);
  assign mem_dq_out = wdata_q;
  assign mem_lb_n   = lane_en_n[0];
  assign mem_ub_n   = lane_en_n[1];

endmodule

// File: rtl/sram_lane_bridge_chk.sv
module sram_lane_bridge_chk #(
  parameter int ADDR_W   = 18,
  parameter int WR_PULSE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe,
  input logic              noop_w
);

  logic [7:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         low_cnt_q <= '0;
    else if (!mem_we_n) low_cnt_q <= low_cnt_q + 8'd1;
    else                low_cnt_q <= '0;
  end

  assert_rsp_at_read_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid && req_ready);

  assert_lane_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_lb_n && mem_ub_n));

  assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n) && $stable(mem_addr)
                        && $stable({mem_lb_n, mem_ub_n}));

  assert_we_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n && $stable(mem_addr)
                        && $stable({mem_lb_n, mem_ub_n}));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> low_cnt_q == 8'(WR_PULSE));

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n && !mem_we_n);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_turnaround_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dq_oe);

  assert_noop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    noop_w |=> req_ready && mem_ce_n && mem_we_n);

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe);

endmodule

bind sram_lane_bridge sram_lane_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .WR_PULSE (WR_PULSE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe),
  .noop_w    (noop_w)
);

// File: tb/sram_lane_bridge_tb.sv
`timescale 1ns/1ps
module sram_lane_bridge_tb;

  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 16;
  localparam int CLK_PS   = 4000;
  localparam int TAA_PS   = 12000;
  localparam int WR_PULSE = 3;
  // restated from R2: whole clocks of access time, plus one settle cycle
  localparam int EXP_RD_LAT = (TAA_PS / CLK_PS) + ((TAA_PS % CLK_PS) != 0 ? 1 : 0) + 2;
  localparam int EXP_WR_LAT = WR_PULSE + 3;
  localparam int NVEC = 12;

  // {write, mask[1:0], addr[17:0], wdata[15:0], expected[15:0]}
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b1, 2'b11, 18'h00003, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 18'h00003, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 18'h00003, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 18'h00003, 16'h0000, 16'h12CD},
    {1'b1, 2'b10, 18'h00003, 16'h5600, 16'h0000},
    {1'b0, 2'b11, 18'h00003, 16'h0000, 16'h56CD},
    {1'b0, 2'b01, 18'h00003, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 18'h00003, 16'h0000, 16'h5600},
    {1'b1, 2'b00, 18'h00003, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 18'h00003, 16'h0000, 16'h56CD},
    {1'b1, 2'b11, 18'h3FFC5, 16'hBEEF, 16'h0000},
    {1'b0, 2'b11, 18'h3FFC5, 16'h0000, 16'hBEEF}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_mask = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [DATA_W-1:0] mem_dq_out;
  logic              mem_dq_oe;
  logic [DATA_W-1:0] mem_dq_in;

  int checks = 0;
  int failures = 0;
  int viol_r5 = 0, viol_r6 = 0, viol_r8 = 0;
  logic prev_oe_low = 1'b0;

  always #2 clk = ~clk;

  sram_lane_bridge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS),
    .TAA_PS(TAA_PS), .WR_PULSE(WR_PULSE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // small RAM model indexed by the low address bits
  logic [DATA_W-1:0] ram [64];
  initial for (int i = 0; i < 64; i++) ram[i] = '0;

  always_comb begin
    mem_dq_in = '0;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = ram[mem_addr[5:0]][7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = ram[mem_addr[5:0]][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
        if (!mem_lb_n) ram[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
        if (!mem_ub_n) ram[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
      end
      if (mem_dq_oe && (mem_ce_n || mem_we_n)) viol_r5++;
      if (mem_dq_oe && (!mem_oe_n || prev_oe_low)) viol_r6++;
      if (req_ready && !mem_ce_n) viol_r8++;
      prev_oe_low = !mem_oe_n;
    end
  end

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_op(input logic wr, input logic [1:0] mask,
                        input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output int lat,
                        output int we_cycles, output logic addr_ok);
    logic done;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mask = mask;
    req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; we_cycles = 0; addr_ok = 1'b1; done = 1'b0; rd = '0;
    while (!done && lat < 50) begin
      if (!mem_ce_n && mem_addr !== addr) addr_ok = 1'b0;
      if (!mem_we_n) we_cycles++;
      if (wr ? req_ready : rsp_valid) begin
        done = 1'b1;
        rd = rsp_rdata;
      end else begin
        @(negedge clk);
        lat++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rd;
    int lat, wec;
    logic aok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during and after reset
    check("R1 ready in reset", req_ready === 1'b1, 32'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n} === 3'b111,
          32'({mem_ce_n, mem_we_n, mem_oe_n}), 32'h7);
    check("R1 lanes idle", {mem_lb_n, mem_ub_n} === 2'b11,
          32'({mem_lb_n, mem_ub_n}), 32'h3);
    check("R1 driver off", mem_dq_oe === 1'b0, 32'(mem_dq_oe), 0);
    check("R1 no response", rsp_valid === 1'b0, 32'(rsp_valid), 0);
    check("R8 ready idle", req_ready === 1'b1, 32'(req_ready), 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [52:0] v;
      int exp_lat, exp_we;
      v = VEC[i];
      run_op(v[52], v[51:50], v[49:32], v[31:16], rd, lat, wec, aok);
      if (v[51:50] == 2'b00) exp_lat = 1;
      else exp_lat = v[52] ? EXP_WR_LAT : EXP_RD_LAT;
      exp_we = (v[52] && v[51:50] != 2'b00) ? WR_PULSE : 0;
      if (v[52]) begin
        check(v[51:50] == 2'b00 ? "R7 noop write latency" : "R4 write latency",
              lat == exp_lat, 32'(lat), 32'(exp_lat));
        check(v[51:50] == 2'b00 ? "R7 noop no strobe" : "R4 write pulse width",
              wec == exp_we, 32'(wec), 32'(exp_we));
      end else begin
        check("R2 read latency", lat == exp_lat, 32'(lat), 32'(exp_lat));
        check(v[51:50] == 2'b11 ? "R2 read data" : "R3 lane read data",
              rd === v[15:0], 32'(rd), 32'(v[15:0]));
        check("R2 no write strobe on read", wec == 0, 32'(wec), 0);
      end
      check("R9 full address", aok === 1'b1, 32'(aok), 1);
    end

    // R7: zero-mask read returns zero on the next cycle
    run_op(1'b0, 2'b00, 18'h00003, 16'h0000, rd, lat, wec, aok);
    check("R7 zero-mask read latency", lat == 1, 32'(lat), 1);
    check("R7 zero-mask read data", rd === 16'h0000, 32'(rd), 0);
    // R3: lanes were stored independently (model contents observed via reads)
    run_op(1'b0, 2'b11, 18'h00003, 16'h0000, rd, lat, wec, aok);
    check("R3 word after lane writes", rd === 16'h56CD, 32'(rd), 32'h56CD);
    // R7: noop write left the word untouched at RAM side too
    check("R7 ram untouched", ram[3] === 16'h56CD, 32'(ram[3]), 32'h56CD);

    @(negedge clk);
    check("R5 driver window", viol_r5 == 0, 32'(viol_r5), 0);
    check("R6 bus turnaround", viol_r6 == 0, 32'(viol_r6), 0);
    check("R8 deselect when ready", viol_r8 == 0, 32'(viol_r8), 0);
    check("R1 back to idle", mem_ce_n === 1'b1 && req_ready === 1'b1,
          32'({mem_ce_n, req_ready}), 32'h3);
    finish_run();
  end

endmodule